// File: doc/BRIEF.md
# Variable-Distribution Programmable AND-OR Array

This block is the sum-of-products plane of a small programmable logic device with 24-pin-class pinout. Twelve dedicated inputs and ten feedback lines from the output cells form 22 array signals. Each signal is offered to the array in true and in complement form. A flat configuration vector chooses which of these literals every product term takes. Each of the ten outputs collects an OR over its own block of product terms. The outputs do not all get the same number of terms: the middle outputs receive the most and the outer ones the fewest.

The same plane also produces one enable term for each output and two terms shared by every register of the device: an asynchronous clear and a synchronous set. The surrounding macrocells take the ten sums, the ten enables and the two shared terms. They add the registers, the polarity choice and the output drivers. A separate configuration block holds the configuration vector. The array itself is purely combinational.

Top module: `pal_and_or_array`

## Requirements
- R1: Array signal s is ded_in[s] for s in 0..11 and fb_in[s-12] for s in 12..21. Column 2*s is the true literal of signal s and column 2*s+1 is its complement. Cell number row*44+column is cfg_bits[row*44+column], and a 1 connects that literal to that row.
- R2: A product term is the AND of all its connected literals. A row with no connected literal evaluates to 1.
- R3: Row 0 (cells 0..43) is the asynchronous-clear term and drives areset_term.
- R4: Row 131 (cells 5764..5807) is the synchronous-set term and drives sset_term.
- R5: Each output k owns a contiguous block of rows starting at row 1, with output 0 first. The first row of the block is the enable term and drives oe_out[k].
- R6: After its enable row, output k has 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 sum rows for k = 0..9. sum_out[k] is the OR of exactly those rows.
- R7: A row that connects both the true and the complement literal of the same signal evaluates to 0, whatever the inputs.
- R8: All outputs follow changes of cfg_bits, ded_in and fb_in with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_bits | input | 5808 | Connection cells, 132 rows of 44 cells |
| ded_in | input | 12 | Dedicated array inputs |
| fb_in | input | 10 | Feedback lines from the output cells |
| sum_out | output | 10 | OR of each output's sum rows |
| oe_out | output | 10 | Per-output enable terms |
| areset_term | output | 1 | Shared asynchronous-clear term |
| sset_term | output | 1 | Shared synchronous-set term |

## Verification
The assertions hold at all times and cover the local facts. The two literals of each signal are always opposite and follow the input pins. An empty clear row or empty enable row yields 1. A set row or sum block in which every row is contradictory yields 0. Only the bench scenarios can show the row-to-output mapping. They sweep a single live row across all 132 positions, walk each literal into the clear row, and run random configurations of several densities against a behavioural model. That work is what shows the uneven term distribution and the cell numbering.

// File: rtl/pal_array_pkg.sv
`timescale 1ns/1ps
package pal_array_pkg;
  parameter int N_DED   = 12;
  parameter int N_FB    = 10;
  parameter int N_OUT   = 10;
  localparam int N_SIG  = N_DED + N_FB;
  localparam int N_COL  = 2 * N_SIG;
  localparam int MIN_TERMS = 8;

  // sum rows granted to output k: grows by two toward the middle, symmetric
  function automatic int term_count(input int k);
    int d;
    d = (k < N_OUT / 2) ? k : (N_OUT - 1 - k);
    return MIN_TERMS + 2 * d;
  endfunction

  // first row (the enable row) of output k's block; row 0 is the clear term
  function automatic int block_base(input int k);
    int acc;
    acc = 1;
    for (int j = 0; j < k; j++) acc += term_count(j) + 1;
    return acc;
  endfunction

  localparam int N_ROW  = block_base(N_OUT) + 1;
  localparam int N_CELL = N_ROW * N_COL;
  localparam int SET_ROW = N_ROW - 1;
endpackage

// File: rtl/pal_literal_expand.sv
`timescale 1ns/1ps
module pal_literal_expand
  import pal_array_pkg::*;
(
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_FB-1:0]  fb_in,
  output logic [N_COL-1:0] lits
);
  logic [N_SIG-1:0] sigs;
  assign sigs = {fb_in, ded_in};

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    assign lits[2*s]   = sigs[s];
    assign lits[2*s+1] = ~sigs[s];
  end
endmodule

// File: rtl/pal_product_row.sv
`timescale 1ns/1ps
module pal_product_row
  import pal_array_pkg::*;
(
  input  logic [N_COL-1:0] cfg_row,
  input  logic [N_COL-1:0] lits,
  output logic             term
);
  // an unconnected cell forces its position to 1, so an empty row gives 1
  assign term = &(lits | ~cfg_row);
endmodule

// File: rtl/pal_sum_collect.sv
`timescale 1ns/1ps
module pal_sum_collect
  import pal_array_pkg::*;
(
  input  logic [N_ROW-1:0] terms,
  output logic [N_OUT-1:0] sum_out,
  output logic [N_OUT-1:0] oe_out,
  output logic             areset_term,
  output logic             sset_term
);
  assign areset_term = terms[0];
  assign sset_term   = terms[SET_ROW];

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int BASE = block_base(k);
    localparam int CNT  = term_count(k);
    assign oe_out[k]  = terms[BASE];
    assign sum_out[k] = |terms[BASE+1 +: CNT];
  end
endmodule

// File: rtl/pal_and_or_array.sv
`timescale 1ns/1ps
module pal_and_or_array
  import pal_array_pkg::*;
(
  input  logic [N_CELL-1:0] cfg_bits,
  input  logic [N_DED-1:0]  ded_in,
  input  logic [N_FB-1:0]   fb_in,
  output logic [N_OUT-1:0]  sum_out,
  output logic [N_OUT-1:0]  oe_out,
  output logic              areset_term,
  output logic              sset_term
);
  logic [N_COL-1:0] lits;
  logic [N_ROW-1:0] terms;

  pal_literal_expand u_lits (
    .ded_in (ded_in),
    .fb_in  (fb_in),
    .lits   (lits)
  );

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    pal_product_row u_row (
      .cfg_row (cfg_bits[r*N_COL +: N_COL]),
      .lits    (lits),
      .term    (terms[r])
    );
  end

  pal_sum_collect u_sum (
    .terms       (terms),
    .sum_out     (sum_out),
    .oe_out      (oe_out),
    .areset_term (areset_term),
    .sset_term   (sset_term)
  );
endmodule

// File: rtl/pal_array_chk.sv
`timescale 1ns/1ps
module pal_array_chk
  import pal_array_pkg::*;
(
  input logic [N_CELL-1:0] cfg_bits,
  input logic [N_DED-1:0]  ded_in,
  input logic [N_FB-1:0]   fb_in,
  input logic [N_COL-1:0]  lits,
  input logic [N_OUT-1:0]  sum_out,
  input logic [N_OUT-1:0]  oe_out,
  input logic              areset_term,
  input logic              sset_term
);
  logic known;
  assign known = !$isunknown({cfg_bits, ded_in, fb_in});

  always_comb begin
    if (known && cfg_bits[N_COL-1:0] == '0) begin
      // R2
      empty_clear_row_chk: assert (areset_term);
    end
    if (known && cfg_bits[SET_ROW*N_COL] && cfg_bits[SET_ROW*N_COL+1]) begin
      // R7
      contra_set_row_chk: assert (!sset_term);
    end
  end

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    always_comb begin
      if (known) begin
        // R1
        lit_pair_chk: assert (lits[2*s] != lits[2*s+1] &&
                              lits[2*s] == ((s < N_DED) ? ded_in[s] : fb_in[s-N_DED]));
      end
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int BASE = block_base(k);
    localparam int CNT  = term_count(k);
    logic all_dead;
    always_comb begin
      all_dead = 1'b1;
      for (int t = 1; t <= CNT; t++)
        if (!(cfg_bits[(BASE+t)*N_COL] && cfg_bits[(BASE+t)*N_COL+1])) all_dead = 1'b0;
    end
    always_comb begin
      if (known && cfg_bits[BASE*N_COL +: N_COL] == '0) begin
        // R5
        empty_enable_row_chk: assert (oe_out[k]);
      end
      if (known && all_dead) begin
        // R6
        dead_sum_block_chk: assert (!sum_out[k]);
      end
    end
  end
endmodule

bind pal_and_or_array pal_array_chk u_chk (
  .cfg_bits    (cfg_bits),
  .ded_in      (ded_in),
  .fb_in       (fb_in),
  .lits        (lits),
  .sum_out     (sum_out),
  .oe_out      (oe_out),
  .areset_term (areset_term),
  .sset_term   (sset_term)
);

// File: tb/tb_pal_and_or_array.sv
`timescale 1ns/1ps
module tb_pal_and_or_array;
  localparam int ROWS = 132;
  localparam int COLS = 44;
  localparam int CELLS = ROWS * COLS;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [CELLS-1:0] cfg;
  logic [11:0] ded;
  logic [9:0]  fb;
  logic [9:0]  sum_o, oe_o;
  logic        ar_o, ss_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  pal_and_or_array dut (
    .cfg_bits (cfg), .ded_in (ded), .fb_in (fb),
    .sum_out (sum_o), .oe_out (oe_o),
    .areset_term (ar_o), .sset_term (ss_o)
  );

  // behavioural model: walk rows with a running index
  function automatic bit row_val(int r);
    for (int s = 0; s < 22; s++) begin
      bit v = (s < 12) ? ded[s] : fb[s-12];
      if (cfg[r*COLS + 2*s] && !v) return 1'b0;
      if (cfg[r*COLS + 2*s + 1] && v) return 1'b0;
    end
    return 1'b1;
  endfunction

  logic [9:0] m_sum, m_oe;
  logic m_ar, m_ss;
  int   owner[ROWS];   // -1 clear, -2 set, 100+k enable of k, k sum of k

  task automatic model();
    int r = 0;
    int per_out[10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
    m_ar = row_val(r); owner[r] = -1; r++;
    for (int k = 0; k < 10; k++) begin
      m_oe[k] = row_val(r); owner[r] = 100 + k; r++;
      m_sum[k] = 1'b0;
      for (int t = 0; t < per_out[k]; t++) begin
        m_sum[k] = m_sum[k] | row_val(r); owner[r] = k; r++;
      end
    end
    m_ss = row_val(r); owner[r] = -2;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string what);
    model();
    chk("R6", what, 32'(sum_o), 32'(m_sum));
    chk("R5", what, 32'(oe_o), 32'(m_oe));
    chk("R3", what, 32'(ar_o), 32'(m_ar));
    chk("R4", what, 32'(ss_o), 32'(m_ss));
  endtask

  task automatic step();
    @(posedge clk);
    #0.5;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // reset state: empty array, every term is 1 (R2)
    cfg = '0; ded = 12'hA5C; fb = 10'h2B3;
    step(); sample();
    chk("R2", "empty array sums", 32'(sum_o), 32'h3FF);
    chk("R2", "empty array enables", 32'(oe_o), 32'h3FF);
    chk("R2", "empty array clear/set", 32'({ar_o, ss_o}), 32'h3);
    check_all("empty array");

    // every row contradictory on signal 0 (R7)
    cfg = '0;
    for (int r = 0; r < ROWS; r++) begin cfg[r*COLS] = 1'b1; cfg[r*COLS+1] = 1'b1; end
    step(); sample();
    chk("R7", "all rows contradictory", 32'({sum_o, oe_o, ar_o, ss_o}), 32'h0);

    // sweep one live row over every position (R3 R4 R5 R6)
    for (int r = 0; r < ROWS; r++) begin
      step();
      cfg[r*COLS +: 2] = 2'b00;
      if (r > 0) cfg[(r-1)*COLS +: 2] = 2'b11;
      sample();
      check_all($sformatf("live row %0d", r));
      if (r == 0)        chk("R3", "row 0 is clear", 32'(ar_o), 32'h1);
      if (r == ROWS - 1) chk("R4", "last row is set", 32'(ss_o), 32'h1);
      if (r == 1)        chk("R5", "row 1 is enable 0", 32'(oe_o), 32'h1);
      if (r == 9)        chk("R6", "row 9 last sum of output 0", 32'(sum_o), 32'h1);
      if (r == 10)       chk("R5", "row 10 is enable 1", 32'(oe_o), 32'h2);
      if (r == 130)      chk("R6", "row 130 last sum of output 9", 32'(sum_o), 32'h200);
    end

    // literal mapping into the clear row (R1)
    cfg = '0;
    for (int s = 0; s < 22; s++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int v = 0; v < 2; v++) begin
          step();
          cfg[COLS-1:0] = '0;
          cfg[2*s + pol] = 1'b1;
          ded = 12'h555; fb = 10'h2AA;
          if (s < 12) ded[s] = v[0]; else fb[s-12] = v[0];
          sample();
          chk("R1", $sformatf("signal %0d pol %0d val %0d", s, pol, v),
              32'(ar_o), 32'((pol == 0) ? v : 1 - v));
        end
      end
    end

    // same-cycle response without a clock edge (R8)
    step();
    cfg = '0; cfg[SETCELL()] = 1'b1; ded = '0; fb = '0;
    #0.5;
    chk("R8", "set follows ded[0]=0", 32'(ss_o), 32'h0);
    ded[0] = 1'b1;
    #0.5;
    chk("R8", "set follows ded[0]=1", 32'(ss_o), 32'h1);

    // random configurations of several densities (R2 R6)
    for (int c = 0; c < 30; c++) begin
      int dens = (c % 3 == 0) ? 6 : ((c % 3 == 1) ? 20 : 60);
      step();
      for (int i = 0; i < CELLS; i++) cfg[i] = ($urandom_range(0, dens) == 0);
      for (int v = 0; v < 15; v++) begin
        if (v > 0) step();
        ded = 12'($urandom); fb = 10'($urandom);
        sample();
        check_all($sformatf("random cfg %0d vec %0d", c, v));
      end
    end

    finish_run();
  end

  function automatic int SETCELL();
    return (ROWS - 1) * COLS;   // true literal of ded_in[0] in the set row
  endfunction
endmodule